// File: doc/BRIEF.md
# Card Erase and Busy Sequencer

This block sits on the card side of a removable flash card's command interface. Command decoding happens elsewhere. Each decoded command reaches this block as an opcode and a 32-bit argument, with a one-cycle valid strobe. The block records the first and the last erase group of a range. It starts an erase when the erase command finds a complete and ordered range. It also starts a programming operation when a write-protect set or clear command arrives. For the whole operation it pulls data line 0 low, and it releases the line when a programmable duration has expired.

The card can be deselected while an operation is still running. In that case the block stops driving the line, but it keeps counting the operation down. If the card is selected again before the operation finishes, the block drives busy again after the same response gap that precedes busy on a new operation. Data line 0 is shown as a drive enable (`dat0_oe`) and a drive value (`dat0_o`, always low). A drive enable of zero means high impedance.

Top module: `erase_busy_seq`

## Requirements
- R1: After reset the card is deselected and `op_busy`, `dat0_oe` and `seq_err` are all 0.
- R2: Opcode 35 latches the start group and opcode 36 latches the end group, each from arg[15:0]. Opcode 38 with both latched and end >= start makes `op_busy` go to 1 at the command edge. `dat0_oe` goes to 1 RSP_GAP cycles later and stays at 1 for (end-start+1)*grp_cycles cycles, with `dat0_o` at 0. Then both return to 0.
- R3: Opcode 38 without a latched start, without a latched end, or with end < start sets `seq_err` and starts no operation.
- R4: Opcode 28 (set write protect) and opcode 29 (clear write protect) each start an operation with the R2 timing that lasts grp_cycles cycles.
- R5: A grp_cycles value of 0 is treated as 1.
- R6: While the card is deselected, `dat0_oe` is 0 even when an operation is running. The operation keeps counting, so `op_busy` falls at the same cycle as it would if the card had stayed selected.
- R7: A select command that arrives while an operation runs on a deselected card makes `dat0_oe` return to 1 RSP_GAP cycles after the select edge.
- R8: Any command other than 35 or 36 that is accepted between the range commands clears both latches.
- R9: Opcodes 28, 29, 35, 36 and 38 are ignored while the card is deselected or `op_busy` is 1.
- R10: `seq_err` stays at 1 until the next accepted opcode 35 clears it.
- R11: Opcode 7 with arg[31:16] equal to `own_rca` selects the card. Opcode 7 with any other address deselects it.
- R12: Once an erase has been launched, its range latches are empty, so a repeated opcode 38 raises `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 6 | Command opcode |
| cmd_arg | input | 32 | Command argument |
| own_rca | input | 16 | Card address compared on select |
| grp_cycles | input | CPG_W | Busy clocks per erase group, and per write-protect operation |
| dat0_oe | output | 1 | Drive enable for data line 0 |
| dat0_o | output | 1 | Drive value for data line 0 (always 0) |
| op_busy | output | 1 | Operation pending or running |
| seq_err | output | 1 | Erase sequence error flag |
| card_sel | output | 1 | Card is selected |

## Verification
The bench targets the following corner cases:
- **Deselect in the middle of an operation.** A design that stopped the counter would end late. A design that kept driving would hold the line while another card owns the bus.
- **Reselect during busy.** A design without the response gap drives at once, which collides with the select response. A design that forgot the operation would never show busy again.
- **Erase orderings.** The bench sends a missing start, a missing end, an intervening command, end below start, and a single-group range. A wrong range check either erases a garbage span or flags a good one.
- **Commands while busy or deselected.** If the block accepted them, a later lone erase would launch instead of raising the error.

// File: rtl/erase_busy_seq.sv
module erase_busy_seq #(
  parameter int GRP_W   = 16,
  parameter int CPG_W   = 16,
  parameter int RSP_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_op,
  input  logic [31:0]      cmd_arg,
  input  logic [15:0]      own_rca,
  input  logic [CPG_W-1:0] grp_cycles,
  output logic             dat0_oe,
  output logic             dat0_o,
  output logic             op_busy,
  output logic             seq_err,
  output logic             card_sel
);
  localparam int CNT_W = GRP_W + 1 + CPG_W;
  localparam int GAP_W = $clog2(RSP_GAP + 1);
  localparam logic [5:0] OP_SEL = 6'd7,  OP_WPS = 6'd28, OP_WPC = 6'd29,
                         OP_GS  = 6'd35, OP_GE  = 6'd36, OP_ERS = 6'd38;

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_RUN} st_t;
  st_t state;

  logic [GRP_W-1:0] first_q, last_q;
  logic             has_first, has_last;
  logic [GAP_W-1:0] gap_q, hold_q;
  logic [CNT_W-1:0] run_q;

  wire sel_cmd = cmd_valid && cmd_op == OP_SEL;
  wire addr_hit = cmd_arg[31:16] == own_rca;
  wire acc = cmd_valid && card_sel && state == S_IDLE && cmd_op != OP_SEL;
  wire c_first = acc && cmd_op == OP_GS;
  wire c_last = acc && cmd_op == OP_GE;
  wire c_ers = acc && cmd_op == OP_ERS;
  wire c_wp = acc && (cmd_op == OP_WPS || cmd_op == OP_WPC);
  wire range_ok = has_first && has_last && last_q >= first_q;
  wire go_ers = c_ers && range_ok;
  wire bad_ers = c_ers && !range_ok;
  wire clr_rng = (acc && !c_first && !c_last) || sel_cmd;

  wire [GRP_W:0]   n_grp = {1'b0, last_q} - {1'b0, first_q} + 1'b1;
  wire [CPG_W-1:0] cpg = (grp_cycles == '0) ? CPG_W'(1) : grp_cycles;
  wire [CNT_W-1:0] dur = go_ers ? CNT_W'(n_grp) * CNT_W'(cpg) : CNT_W'(cpg);

  assign dat0_o  = 1'b0;
  assign op_busy = state != S_IDLE;
  assign dat0_oe = card_sel && state == S_RUN && hold_q == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_first <= 1'b0;
      has_last  <= 1'b0;
      first_q   <= '0;
      last_q    <= '0;
    end else if (c_first) begin
      first_q   <= cmd_arg[GRP_W-1:0];
      has_first <= 1'b1;
    end else if (c_last) begin
      last_q    <= cmd_arg[GRP_W-1:0];
      has_last  <= 1'b1;
    end else if (clr_rng) begin
      has_first <= 1'b0;
      has_last  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       seq_err <= 1'b0;
    else if (bad_ers) seq_err <= 1'b1;
    else if (c_first) seq_err <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      card_sel <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (sel_cmd) card_sel <= addr_hit;
      if (sel_cmd && addr_hit && !card_sel) hold_q <= GAP_W'(RSP_GAP);
      else if (hold_q != '0)                hold_q <= hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      gap_q <= '0;
      run_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (go_ers || c_wp) begin
          state <= S_PEND;
          gap_q <= GAP_W'(RSP_GAP);
          run_q <= dur;
        end
        S_PEND: if (gap_q <= GAP_W'(1)) state <= S_RUN;
                else gap_q <= gap_q - 1'b1;
        S_RUN:  if (run_q <= CNT_W'(1)) state <= S_IDLE;
                else run_q <= run_q - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_busy_seq_chk.sv
module erase_busy_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [5:0]  cmd_op,
  input logic [31:0] cmd_arg,
  input logic [15:0] own_rca,
  input logic        dat0_oe,
  input logic        dat0_o,
  input logic        op_busy,
  input logic        seq_err,
  input logic        card_sel
);
  a_r2_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    dat0_oe |-> !dat0_o);
  a_r2_oe_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    dat0_oe |-> op_busy);
  a_r2_gap_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> !dat0_oe);
  a_r3_err_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> !op_busy);
  a_r6_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !card_sel |-> !dat0_oe);
  a_r7_gap_reselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_sel) |-> !dat0_oe);
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && cmd_valid && cmd_op == 6'd35) |=> $stable(seq_err));
  a_r11_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 6'd7 && cmd_arg[31:16] != own_rca) |=> !card_sel);
endmodule

bind erase_busy_seq erase_busy_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_arg(cmd_arg), .own_rca(own_rca), .dat0_oe(dat0_oe), .dat0_o(dat0_o),
  .op_busy(op_busy), .seq_err(seq_err), .card_sel(card_sel));

// File: tb/erase_busy_seq_test.sv
module erase_busy_seq_test;
  localparam int GAP = 2;
  localparam logic [15:0] RCA = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [5:0]  cmd_op = '0;
  logic [31:0] cmd_arg = '0;
  logic [15:0] own_rca = RCA;
  logic [15:0] grp_cycles = 16'd3;
  logic dat0_oe, dat0_o, op_busy, seq_err, card_sel;
  int nchk = 0, nfail = 0, cyc = 0;

  erase_busy_seq #(.GRP_W(16), .CPG_W(16), .RSP_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .own_rca(own_rca), .grp_cycles(grp_cycles),
    .dat0_oe(dat0_oe), .dat0_o(dat0_o), .op_busy(op_busy),
    .seq_err(seq_err), .card_sel(card_sel));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_len(int s, int e, int c);
    return (e - s + 1) * ((c == 0) ? 1 : c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] op, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic measure(input int c0, output int first, output int cnt, output int dur);
    int guard = 0;
    first = -1; cnt = 0;
    while (op_busy && guard < 100000) begin
      if (dat0_oe) begin
        cnt++;
        if (first < 0) first = cyc - c0;
      end
      @(negedge clk);
      guard++;
    end
    dur = cyc - c0;
  endtask

  task automatic run_op(input string req, input int len);
    int c0, f, n, d;
    c0 = cyc;
    check(op_busy == 1'b1, req, op_busy, 1);
    measure(c0, f, n, d);
    check(f == GAP, req, f, GAP);
    check(n == len, req, n, len);
    check(d == GAP + len, req, d, GAP + len);
  endtask

  initial begin
    #600000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!card_sel && !op_busy && !dat0_oe && !seq_err, "R1",
          {card_sel, op_busy, dat0_oe, seq_err}, 0);
    // R9: deselected, erase ignored
    send(6'd38, 0);
    check(!op_busy && !seq_err, "R9", {op_busy, seq_err}, 0);
    // R11
    send(6'd7, {16'h9999, 16'h0});
    check(!card_sel, "R11", card_sel, 0);
    send(6'd7, {RCA, 16'h0});
    check(card_sel, "R11", card_sel, 1);
    // R2 basic erase groups 2..4, 3 cycles each
    grp_cycles = 16'd3;
    send(6'd35, 32'd2); send(6'd36, 32'd4); send(6'd38, 0);
    check(!dat0_o, "R2", dat0_o, 0);
    run_op("R2", 9);
    check(!dat0_oe, "R2", dat0_oe, 0);
    // R12
    send(6'd38, 0);
    check(seq_err && !op_busy, "R12", {seq_err, op_busy}, 2);
    // R10
    send(6'd35, 32'd1);
    check(!seq_err, "R10", seq_err, 0);
    // R3 end below start
    send(6'd36, 32'd0); send(6'd38, 0);
    check(seq_err && !op_busy, "R3", {seq_err, op_busy}, 2);
    // R8
    send(6'd35, 32'd1); send(6'd13, 0); send(6'd36, 32'd5); send(6'd38, 0);
    check(seq_err && !op_busy, "R8", {seq_err, op_busy}, 2);
    // R4 set and clear write protect
    grp_cycles = 16'd7;
    send(6'd28, 0); run_op("R4", 7);
    send(6'd29, 0); run_op("R4", 7);
    // R5
    grp_cycles = 16'd0;
    send(6'd29, 0); run_op("R5", 1);
    send(6'd35, 32'd3); send(6'd36, 32'd6); send(6'd38, 0); run_op("R5", 4);
    // R9 busy ignore
    grp_cycles = 16'd10;
    send(6'd28, 0);
    send(6'd35, 32'd1); send(6'd36, 32'd2);
    while (op_busy) @(negedge clk);
    send(6'd38, 0);
    check(seq_err && !op_busy, "R9", {seq_err, op_busy}, 2);
    // R9 deselected ignore
    send(6'd35, 32'd0);
    send(6'd7, {16'h0001, 16'h0});
    send(6'd35, 32'd0); send(6'd36, 32'd1); send(6'd38, 0);
    check(!op_busy && !seq_err, "R9", {op_busy, seq_err}, 0);
    send(6'd28, 0);
    check(!op_busy, "R9", op_busy, 0);
    send(6'd7, {RCA, 16'h0});
    send(6'd38, 0);
    check(seq_err && !op_busy, "R9", {seq_err, op_busy}, 2);
    // R6 / R7 deselect and reselect mid-operation
    grp_cycles = 16'd20;
    send(6'd28, 0);
    c0 = cyc;
    send(6'd7, {16'h0002, 16'h0});
    check(!dat0_oe && op_busy, "R6", {dat0_oe, op_busy}, 1);
    repeat (5) @(negedge clk);
    check(!dat0_oe, "R6", dat0_oe, 0);
    send(6'd7, {RCA, 16'h0});
    check(!dat0_oe, "R7", dat0_oe, 0);
    repeat (GAP) @(negedge clk);
    check(dat0_oe, "R7", dat0_oe, 1);
    while (op_busy) @(negedge clk);
    check(cyc - c0 == GAP + 20, "R6", cyc - c0, GAP + 20);
    // R6: stay deselected to the end, then reselect
    grp_cycles = 16'd6;
    send(6'd29, 0);
    c0 = cyc;
    send(6'd7, {16'h0003, 16'h0});
    while (op_busy) begin
      if (dat0_oe) check(0, "R6", 1, 0);
      @(negedge clk);
    end
    check(cyc - c0 == GAP + 6, "R6", cyc - c0, GAP + 6);
    send(6'd7, {RCA, 16'h0});
    repeat (GAP + 1) @(negedge clk);
    check(!dat0_oe, "R7", dat0_oe, 0);
    // random erase sequences
    for (int i = 0; i < 60; i++) begin
      int s, e, c, m;
      bit good;
      s = $urandom % 8; e = $urandom % 8; c = $urandom % 5; m = $urandom % 6;
      grp_cycles = 16'(c);
      if (m != 0) send(6'd35, 32'(s));
      if (m == 2) send(6'd13, 0);
      if (m != 1) send(6'd36, 32'(e));
      send(6'd38, 0);
      good = (m >= 3) && (e >= s);
      if (good) begin
        check(!seq_err, "R10", seq_err, 0);
        run_op("R2", exp_len(s, e, c));
      end else begin
        check(seq_err && !op_busy, "R3", {seq_err, op_busy}, 2);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule